// File: doc/BRIEF.md
# Stack Arithmetic Processor

This block is a small processor that keeps its working values on an internal operand stack instead of in named registers. Only two instructions name anything: one copies a word from data memory onto the stack, the other stores the top word back to data memory and discards it. Four arithmetic instructions take no operand. Each one consumes the two uppermost entries and leaves one result in their place.

Instructions are read from a program memory at the address held in a program counter. Each instruction takes a fetch cycle and then an execute cycle. Data memory is read combinationally during execute and written with a one-cycle write strobe. The processor runs until it executes a stop instruction or hits a fault. A fault is stack overflow, stack underflow or division by zero. Once stopped, it stays idle until reset.

Top module: `stack_calc`

## Requirements
- R1: After reset the processor fetches from address 0 with an empty stack, and `halted`, `fault` and `dmem_we` are all low.
- R2: An instruction word carries the opcode in bits [15:12] and an address in bits [11:0]. Every instruction uses one fetch cycle and one execute cycle, and the program counter advances by one per fetch. A program of k instructions ending in the stop instruction raises `halted` exactly 2k cycles after reset is released, with `imem_addr` equal to k.
- R3: Opcode 0 reads the data word at its address and places it on top of the stack.
- R4: Opcode 1 writes the top word to data memory at its address and removes it, so successive stores return values in reverse order of loading.
- R5: Opcodes 2, 3, 4 and 5 compute top + below, top - below, top * below and top / below. The top entry is the left operand. Both entries are replaced by the single result, so the depth drops by one.
- R6: Addition and subtraction wrap modulo 2^16. Multiplication keeps the low 16 bits of the product. Division is unsigned and truncates.
- R7: Opcode 15 stops the processor. `halted` stays high, and after that the program counter does not move and nothing is written.
- R8: Loading a ninth word onto a full 8-entry stack sets `fault` and stops the processor.
- R9: A store with an empty stack, or an arithmetic instruction with fewer than two entries, sets `fault` and stops the processor without writing data memory.
- R10: Division with a zero entry below the top sets `fault`, stops the processor and leaves the stack contents unchanged.
- R11: Opcodes 6 to 14 do nothing beyond advancing to the next instruction.
- R12: `dmem_we` is high only during the execute cycle of a successful store, and for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 12 | Program memory address (program counter) |
| imem_rdata | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 12 | Data memory address |
| dmem_rdata | input | 16 | Data word at `dmem_addr`, combinational |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 16 | Data word to write |
| halted | output | 1 | Processor has stopped |
| fault | output | 1 | Sticky fault indication |

## Verification
On every cycle, the assertions check the following:
- the stack depth stays within its bound and changes by at most one entry;
- the fault and stop indications are sticky, and a fault always stops the processor;
- the write strobe is a single-cycle pulse that never appears after stopping;
- the program counter freezes once stopped.

Only the bench scenarios can show the following:
- the operand order of the four operators;
- the wrap, truncation and unsigned-division arithmetic over a sweep of operand pairs;
- the last-in-first-out order of stores;
- the exact cycle count per instruction;
- that each fault case leaves data memory untouched.

// File: rtl/stack_calc.sv
module stack_calc #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [AW+3:0] imem_rdata,
  output logic [AW-1:0] dmem_addr,
  input  logic [DW-1:0] dmem_rdata,
  output logic          dmem_we,
  output logic [DW-1:0] dmem_wdata,
  output logic          halted,
  output logic          fault
);
  localparam int IW  = AW + 4;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IXW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_STOP} state_t;
  localparam logic [3:0] OP_LOAD = 4'd0, OP_STORE = 4'd1, OP_ADD = 4'd2,
                         OP_SUB = 4'd3, OP_MUL = 4'd4, OP_DIV = 4'd5, OP_STOP = 4'd15;

  state_t          state;
  logic [IW-1:0]   ir;
  logic [AW-1:0]   pc;
  logic [SPW-1:0]  sp;
  logic            fault_q;
  logic [DW-1:0]   stk [DEPTH];

  wire [3:0]     op   = ir[IW-1 -: 4];
  wire [IXW-1:0] t_ix = IXW'(sp - SPW'(1));
  wire [IXW-1:0] b_ix = IXW'(sp - SPW'(2));
  wire [IXW-1:0] p_ix = IXW'(sp);
  wire [DW-1:0]  top  = stk[t_ix];
  wire [DW-1:0]  nxt  = stk[b_ix];
  wire           exec = (state == S_EXEC);
  wire           is_bin = (op >= OP_ADD) && (op <= OP_DIV);

  logic [DW-1:0]   res;
  logic [2*DW-1:0] prod;
  assign prod = top * nxt;
  always_comb begin
    case (op)
      OP_ADD:  res = top + nxt;
      OP_SUB:  res = top - nxt;
      OP_MUL:  res = prod[DW-1:0];
      OP_DIV:  res = (nxt == '0) ? '0 : top / nxt;
      default: res = '0;
    endcase
  end

  wire err = exec && (
      (op == OP_LOAD  && sp == SPW'(DEPTH)) ||
      (op == OP_STORE && sp == '0) ||
      (is_bin && sp < SPW'(2)) ||
      (op == OP_DIV && sp >= SPW'(2) && nxt == '0));

  assign imem_addr  = pc;
  assign dmem_addr  = ir[AW-1:0];
  assign dmem_wdata = top;
  assign dmem_we    = exec && (op == OP_STORE) && !err;
  assign halted     = (state == S_STOP);
  assign fault      = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_FETCH;
      ir      <= '0;
      pc      <= '0;
      sp      <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= imem_rdata;
          pc    <= pc + AW'(1);
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          if (err) begin
            fault_q <= 1'b1;
            state   <= S_STOP;
          end else if (op == OP_LOAD) sp <= sp + SPW'(1);
          else if (op == OP_STORE || is_bin) sp <= sp - SPW'(1);
          else if (op == OP_STOP) state <= S_STOP;
        end
        default: state <= S_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (exec && !err) begin
      if (op == OP_LOAD) stk[p_ix] <= dmem_rdata;
      else if (is_bin)   stk[b_ix] <= res;
    end
  end
endmodule

// File: rtl/stack_calc_chk.sv
module stack_calc_chk #(
  parameter int AW    = 12,
  parameter int SPW   = 4,
  parameter int DEPTH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           halted,
  input logic           fault,
  input logic           dmem_we,
  input logic [AW-1:0]  imem_addr,
  input logic [SPW-1:0] sp
);
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sp <= SPW'(DEPTH)); // R8
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (sp == $past(sp) + SPW'(1) || sp == $past(sp) - SPW'(1))); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault); // R9
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n) fault |-> halted); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R7
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(imem_addr)); // R7
  AST_NO_WRITE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !dmem_we); // R12
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) dmem_we |=> !dmem_we); // R12
endmodule

bind stack_calc stack_calc_chk #(.AW(AW), .SPW(SPW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .fault(fault),
  .dmem_we(dmem_we), .imem_addr(imem_addr), .sp(sp)
);

// File: tb/tb_stack_calc.sv
module tb_stack_calc;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [11:0] imem_addr, dmem_addr;
  logic [15:0] imem_rdata, dmem_rdata, dmem_wdata;
  logic dmem_we, halted, fault;

  logic [15:0] imem [4096];
  logic [15:0] dmem [4096];
  int wcnt = 0, checks = 0, fails = 0, cyc = 0;

  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_we) begin dmem[dmem_addr] <= dmem_wdata; wcnt <= wcnt + 1; end

  stack_calc dut (.clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .halted(halted), .fault(fault));

  function automatic logic [15:0] ins(input int op, input int a);
    return {4'(op), 12'(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic run();
    rst_n = 0; wcnt = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!halted && cyc < 500);
    if (!halted) chk(0, "watchdog", cyc, 0);
  endtask

  initial begin
    automatic logic [15:0] vals[8] = '{16'h0, 16'h1, 16'h2, 16'h7, 16'hFF, 16'h8000, 16'hFFFF, 16'd12345};
    for (int i = 0; i < 4096; i++) begin imem[i] = 16'hF000; dmem[i] = 16'h0; end

    // R1: reset state
    rst_n = 0; @(negedge clk);
    chk(imem_addr == 0 && !halted && !fault && !dmem_we, "R1", {imem_addr, halted, fault}, 0);

    // R5 R6 R3 R4: operator sweep, top is left operand
    for (int op = 2; op <= 5; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++) begin
          automatic logic [15:0] a = vals[ia], b = vals[ib], e;
          automatic logic [31:0] p = a * b;
          dmem[10] = b; dmem[11] = a; dmem[20] = 16'hDEAD;
          imem[0] = ins(0, 10); imem[1] = ins(0, 11); imem[2] = ins(op, 0);
          imem[3] = ins(1, 20); imem[4] = ins(15, 0);
          run();
          case (op)
            2: e = a + b;
            3: e = a - b;
            4: e = p[15:0];
            default: e = (b == 0) ? 16'hDEAD : a / b;
          endcase
          if (op == 5 && b == 0)
            chk(fault && halted && wcnt == 0 && dmem[20] == 16'hDEAD, "R10", {fault, 16'(wcnt)}, 17'h10000);
          else
            chk(!fault && dmem[20] == e, op == 5 ? "R6" : "R5", dmem[20], e);
        end

    // R2: cycle count and pc after stop
    imem[0] = ins(9, 0); imem[1] = ins(9, 0); imem[2] = ins(15, 0);
    run();
    chk(cyc == 6, "R2 cycles", cyc, 6);
    chk(imem_addr == 3, "R2 pc", imem_addr, 3);

    // R7: stop is permanent
    repeat (5) @(negedge clk);
    chk(halted && imem_addr == 3 && !fault, "R7", imem_addr, 3);

    // R4 R8: fill stack, then store in reverse order
    for (int i = 0; i < 8; i++) begin dmem[100 + i] = 16'(16'h1111 * (i + 1)); imem[i] = ins(0, 100 + i); end
    for (int i = 0; i < 8; i++) imem[8 + i] = ins(1, 200 + i);
    imem[16] = ins(15, 0);
    run();
    chk(!fault && wcnt == 8, "R4 count", wcnt, 8);
    for (int i = 0; i < 8; i++) chk(dmem[200 + i] == 16'(16'h1111 * (8 - i)), "R4 order", dmem[200 + i], 16'(16'h1111 * (8 - i)));

    // R8: ninth load overflows
    for (int i = 0; i < 9; i++) imem[i] = ins(0, 100);
    imem[9] = ins(1, 300); imem[10] = ins(15, 0);
    run();
    chk(fault && halted && imem_addr == 9 && wcnt == 0, "R8", {fault, imem_addr}, 13'h1009);

    // R9: store on empty stack
    dmem[301] = 16'hBEEF;
    imem[0] = ins(1, 301); imem[1] = ins(15, 0);
    run();
    chk(fault && wcnt == 0 && dmem[301] == 16'hBEEF && imem_addr == 1, "R9 store", {fault, 16'(wcnt)}, 17'h10000);

    // R9: operator with one entry
    imem[0] = ins(0, 100); imem[1] = ins(3, 0); imem[2] = ins(1, 302); imem[3] = ins(15, 0);
    run();
    chk(fault && wcnt == 0 && imem_addr == 2, "R9 operator", {fault, imem_addr}, 13'h1002);

    // R11: reserved opcodes have no effect
    for (int op = 6; op <= 14; op++) begin
      dmem[50] = 16'(16'h0A00 + op); dmem[60] = 0;
      imem[0] = ins(0, 50); imem[1] = ins(op, 60); imem[2] = ins(1, 60); imem[3] = ins(15, 0);
      run();
      chk(!fault && dmem[60] == 16'(16'h0A00 + op) && cyc == 8, "R11", dmem[60], 16'(16'h0A00 + op));
    end

    // R12: single write pulse per store
    dmem[70] = 16'h1234; dmem[71] = 0;
    imem[0] = ins(0, 70); imem[1] = ins(1, 71); imem[2] = ins(15, 0);
    run();
    chk(wcnt == 1 && dmem[71] == 16'h1234, "R12", wcnt, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule